// File: doc/BRIEF.md
# Buffered SPI Master

This block is an SPI master that a host drives through an 8-bit register bus using classic single-access Wishbone cycles. The host writes bytes into a four-entry transmit queue. Whenever the block is enabled and that queue holds a byte, the shift engine takes the byte and shifts it out most significant bit first. At the same time it assembles the byte returned on the serial input and places it in a four-entry receive queue, which the host drains by reading the data register.

Software picks the serial clock polarity, the clock phase and the serial clock rate. The half period of the serial clock is a power of two of the system clock, so the block works over a wide range of system clock frequencies. A transfer counter raises a sticky interrupt flag after a programmed number of completed bytes, from one to four, rather than after every byte. When enable is cleared, any transfer in flight stops at once, both queues are emptied and the serial clock returns to its idle level.

Top module: `spi_buffered_master`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0x05, `sck_o` is low and `wb_int_o` is low.
- R2: A bus access is carried out on the first clock edge where `wb_cyc_i` and `wb_stb_i` are both high. `wb_ack_o` goes high one cycle later and stays high for exactly one cycle, and read data on `wb_dat_o` is valid while `wb_ack_o` is high.
- R3: The control register reads back the value last written. Its bit fields are: bits [1:0] the divider select, bits [3:2] the interrupt count minus one, bit 4 phase, bit 5 polarity, bit 6 interrupt enable, bit 7 enable.
- R4: Each byte is sent MSB first on `mosi_o`, in the order it was written. With phase 0 the first bit is on `mosi_o` one clock after the byte is taken, before the first serial clock edge, and bits change on trailing edges. With phase 1 bits change on leading edges.
- R5: Received bits are sampled on the leading edge when phase is 0 and on the trailing edge when phase is 1, MSB first. Reading the data register (address 2) pops the oldest received byte.
- R6: The half period of `sck_o` is 2^div system clocks. The transfer starts one clock after the byte enters the empty engine, and the first edge comes one half period later. A byte makes 16 edges, and between transfers and while disabled `sck_o` rests at the polarity bit.
- R7: The status bits are: bit 0 transmit queue empty, bit 1 transmit queue full, bit 2 receive queue empty, bit 3 receive queue full, bit 6 write collision, bit 7 interrupt flag. The transmit queue holds four bytes ahead of the byte being shifted.
- R8: A data write while the transmit queue is full is discarded and sets the write-collision bit. Writing 1 to bit 6 of the status register clears that bit.
- R9: When a byte is received while the receive queue is full, the oldest stored byte is discarded.
- R10: The interrupt flag is set when the completed-transfer count reaches the programmed count plus one, and the count then restarts from zero. Writing 1 to status bit 7 clears the flag, and `wb_int_o` equals the flag ANDed with the interrupt-enable bit.
- R11: Clearing enable aborts the current transfer, empties both queues and sends `sck_o` to the polarity level. Data writes made while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | 2 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| wb_int_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Register reads and writes take effect on the edge after the strobe is driven, and the bench samples acknowledge and read data on the falling edge that follows. A byte written to an idle engine is taken one clock later, reaches its first serial edge after one more half period, and lands in the receive queue 16 half periods plus two clocks after the write. The bench therefore counts falling edges to measure the first edge and the half period exactly. It reads status and data only after a wait of 16·2^div plus a small margin per queued byte. A bench slave model counts the real sampling edges, so an extra or a missing edge shows up as a wrong byte count.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int BYTE_W    = 8;
    localparam int DIV_SEL_W = 2;
    localparam int XCNT_W    = 2;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;

    typedef struct packed {
        logic                 en;
        logic                 ien;
        logic                 cpol;
        logic                 cpha;
        logic [XCNT_W-1:0]    xfer_lim;
        logic [DIV_SEL_W-1:0] div_sel;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              irq;
        logic              wcol;
        logic [XCNT_W-1:0] xfer_cnt;
        logic              ack;
        logic [BYTE_W-1:0] rdat;
    } regs_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 4,
    parameter bit OVERWRITE = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_pop, do_push, drop_old;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CW'(DEPTH));
    assign rdata_o = mem_q[q.rp];

    always_comb begin
        d        = q;
        do_pop   = pop_i & ~empty_o;
        do_push  = push_i & (~full_o | do_pop | OVERWRITE);
        drop_old = push_i & full_o & ~do_pop & OVERWRITE;
        if (flush_i) begin
            d = '0;
        end else begin
            if (do_push)           d.wp = nxt(q.wp);
            if (do_pop || drop_old) d.rp = nxt(q.rp);
            if (do_push && !do_pop && !drop_old) d.cnt = q.cnt + CW'(1);
            else if (do_pop && !do_push)         d.cnt = q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push && !flush_i) mem_q[q.wp] <= wdata_i;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int BITS      = 8,
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic                 cpol_i,
    input  logic                 cpha_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    input  logic                 tx_ready_i,
    input  logic [BITS-1:0]      tx_byte_i,
    input  logic                 miso_i,
    output logic                 take_o,
    output logic                 done_o,
    output logic [BITS-1:0]      rx_byte_o,
    output logic                 sck_o,
    output logic                 mosi_o
);
    localparam int DIV_W  = 2 ** DIV_SEL_W;
    localparam int EDGES  = 2 * BITS;
    localparam int EDGE_W = $clog2(EDGES);

    typedef struct packed {
        logic              run;
        logic [DIV_W-1:0]  div_cnt;
        logic [EDGE_W-1:0] edge_idx;
        logic [BITS-1:0]   tx_sh;
        logic [BITS-1:0]   rx_sh;
        logic              sck;
        logic              mosi;
        logic              done;
    } eng_st_t;

    eng_st_t q, d;
    logic [DIV_W-1:0] half_m1;
    logic sample_edge, last_edge;

    assign sck_o     = q.sck;
    assign mosi_o    = q.mosi;
    assign done_o    = q.done;
    assign rx_byte_o = q.rx_sh;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        take_o      = 1'b0;
        half_m1     = (DIV_W'(1) << div_sel_i) - DIV_W'(1);
        // even edge index = leading edge; sampling side chosen by phase
        sample_edge = ~q.edge_idx[0] ^ cpha_i;
        last_edge   = (q.edge_idx == EDGE_W'(EDGES - 1));
        if (!en_i) begin
            d.run      = 1'b0;
            d.div_cnt  = '0;
            d.edge_idx = '0;
            d.sck      = cpol_i;
        end else if (!q.run) begin
            d.sck = cpol_i;
            if (tx_ready_i) begin
                take_o     = 1'b1;
                d.run      = 1'b1;
                d.div_cnt  = '0;
                d.edge_idx = '0;
                if (!cpha_i) begin
                    d.mosi  = tx_byte_i[BITS-1];
                    d.tx_sh = {tx_byte_i[BITS-2:0], 1'b0};
                end else begin
                    d.tx_sh = tx_byte_i;
                end
            end
        end else if (q.div_cnt != half_m1) begin
            d.div_cnt = q.div_cnt + DIV_W'(1);
        end else begin
            d.div_cnt = '0;
            d.sck     = ~q.sck;
            if (sample_edge) begin
                d.rx_sh = {q.rx_sh[BITS-2:0], miso_i};
            end else if (!last_edge) begin
                d.mosi  = q.tx_sh[BITS-1];
                d.tx_sh = {q.tx_sh[BITS-2:0], 1'b0};
            end
            if (last_edge) begin
                d.run      = 1'b0;
                d.done     = 1'b1;
                d.edge_idx = '0;
            end else begin
                d.edge_idx = q.edge_idx + EDGE_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end
endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
    import spi_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [1:0]        wb_adr_i,
    input  logic [BYTE_W-1:0] wb_dat_i,
    output logic [BYTE_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    output logic              wb_int_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    regs_t q, d;
    logic req;
    logic tx_push, tx_take, tx_empty, tx_full;
    logic rx_pop, rx_empty, rx_full;
    logic eng_done;
    logic [BYTE_W-1:0] tx_head, rx_head, rx_byte, stat;
    logic flush;
    ctrl_t ctrl_cur;
    logic  irq_cur, wcol_cur;

    assign flush    = ~q.ctrl.en;
    assign wb_dat_o = q.rdat;
    assign wb_ack_o = q.ack;
    assign wb_int_o = q.irq & q.ctrl.ien;
    assign ctrl_cur = q.ctrl;
    assign irq_cur  = q.irq;
    assign wcol_cur = q.wcol;

    spi_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b0)) u_txq (
        .clk_i(clk_i), .rst_i(rst_i), .flush_i(flush),
        .push_i(tx_push), .wdata_i(wb_dat_i), .pop_i(tx_take),
        .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full)
    );

    spi_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b1)) u_rxq (
        .clk_i(clk_i), .rst_i(rst_i), .flush_i(flush),
        .push_i(eng_done), .wdata_i(rx_byte), .pop_i(rx_pop),
        .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full)
    );

    spi_shift_engine #(.BITS(BYTE_W), .DIV_SEL_W(DIV_SEL_W)) u_eng (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(q.ctrl.en),
        .cpol_i(q.ctrl.cpol), .cpha_i(q.ctrl.cpha), .div_sel_i(q.ctrl.div_sel),
        .tx_ready_i(~tx_empty), .tx_byte_i(tx_head), .miso_i(miso_i),
        .take_o(tx_take), .done_o(eng_done), .rx_byte_o(rx_byte),
        .sck_o(sck_o), .mosi_o(mosi_o)
    );

    always_comb begin
        d       = q;
        req     = wb_cyc_i & wb_stb_i & ~q.ack;
        d.ack   = req;
        tx_push = 1'b0;
        rx_pop  = 1'b0;
        stat    = {q.irq, q.wcol, 2'b00, rx_full, rx_empty, tx_full, tx_empty};
        if (req && !wb_we_i) begin
            case (wb_adr_i)
                ADR_CTRL: d.rdat = q.ctrl;
                ADR_STAT: d.rdat = stat;
                ADR_DATA: begin
                    d.rdat = rx_empty ? '0 : rx_head;
                    rx_pop = 1'b1;
                end
                default:  d.rdat = '0;
            endcase
        end
        if (req && wb_we_i) begin
            case (wb_adr_i)
                ADR_CTRL: d.ctrl = wb_dat_i;
                ADR_STAT: begin
                    if (wb_dat_i[7]) d.irq  = 1'b0;
                    if (wb_dat_i[6]) d.wcol = 1'b0;
                end
                ADR_DATA: begin
                    if (q.ctrl.en) begin
                        if (tx_full) d.wcol  = 1'b1;
                        else         tx_push = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (!q.ctrl.en) begin
            d.xfer_cnt = '0;
        end else if (eng_done) begin
            if (q.xfer_cnt == q.ctrl.xfer_lim) begin
                d.irq      = 1'b1;
                d.xfer_cnt = '0;
            end else begin
                d.xfer_cnt = q.xfer_cnt + XCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end
endmodule

module spi_buffered_master_chk
    import spi_pkg::*;
(
    input logic        clk_i,
    input logic        rst_i,
    input logic        wb_cyc_i,
    input logic        wb_stb_i,
    input logic        wb_we_i,
    input logic [1:0]  wb_adr_i,
    input logic [7:0]  wb_dat_i,
    input logic        wb_ack_o,
    input logic        sck_o,
    input ctrl_t       ctrl_cur,
    input logic        irq_cur,
    input logic        wcol_cur,
    input logic        tx_empty,
    input logic        tx_full,
    input logic        rx_empty,
    input logic        rx_full
);
    // R2
    ack_follows_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);
    // R2
    ack_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_ack_o |=> !wb_ack_o);
    // R11
    sck_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ctrl_cur.en |=> (sck_o == $past(ctrl_cur.cpol)));
    // R10
    irq_clear_by_host_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(irq_cur) |-> $past(wb_cyc_i && wb_stb_i && wb_we_i &&
                                 wb_adr_i == ADR_STAT && wb_dat_i[7]));
    // R8
    wcol_from_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wcol_cur) |-> $past(wb_cyc_i && wb_stb_i && wb_we_i && wb_adr_i == ADR_DATA));
    // R7
    txq_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({tx_full, tx_empty}));
    // R9
    rxq_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({rx_full, rx_empty}));
endmodule

bind spi_buffered_master spi_buffered_master_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
    .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
    .wb_ack_o(wb_ack_o), .sck_o(sck_o), .ctrl_cur(ctrl_cur),
    .irq_cur(irq_cur), .wcol_cur(wcol_cur), .tx_empty(tx_empty),
    .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full)
);

// File: tb/tb_spi_buffered_master.sv
`timescale 1ns/1ps
module tb_spi_buffered_master;
    import spi_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [1:0] adr = 2'd0;
    logic [7:0] wdat = 8'h00;
    logic [7:0] rdat;
    logic       ack, irq_o, sck, mosi, miso;

    spi_buffered_master dut (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
        .wb_int_o(irq_o), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [7:0] resp(input int k);
        return 8'h3C ^ (8'(k) * 8'h29);
    endfunction

    // slave model: counts real sampling edges, returns resp(k) for byte k
    logic       model_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
    logic [7:0] sl_sh = 8'h00, sl_cap = 8'h00;
    int         sl_n = 0, sl_bytes = 0;
    logic [7:0] cap_log [0:15];
    assign miso = sl_sh[7];

    always @(sck) begin
        if (model_on && ((sck !== m_cpol) ^ m_cpha)) begin
            sl_cap = {sl_cap[6:0], mosi};
            sl_sh  = sl_sh << 1;
            sl_n++;
            if (sl_n == 8) begin
                if (sl_bytes < 16) cap_log[sl_bytes] = sl_cap;
                sl_bytes++;
                sl_sh = resp(sl_bytes);
                sl_n  = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = v;
        @(negedge clk); cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
        @(negedge clk); v = rdat; cyc = 1'b0; stb = 1'b0;
    endtask

    task automatic model_rst();
        model_on = 1'b0; sl_n = 0; sl_bytes = 0; sl_sh = resp(0); sl_cap = 8'h00;
    endtask

    task automatic setup(input logic [7:0] c);
        model_rst();
        bus_wr(ADR_CTRL, 8'h00);
        bus_wr(ADR_STAT, 8'hC0);
        bus_wr(ADR_CTRL, c);
        idle(2);
        m_cpol = c[5]; m_cpha = c[4]; model_on = 1'b1;
    endtask

    // {control, transmit byte}
    localparam logic [15:0] VEC [0:7] = '{16'h80A5, 16'h913C, 16'hA281, 16'hB37E,
                                          16'h8001, 16'h93F0, 16'hA05A, 16'hB1C3};

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int t;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state, R2 acknowledge timing
        chk("R1 sck reset", {7'd0, sck}, 8'h00);
        chk("R1 int reset", {7'd0, irq_o}, 8'h00);
        @(negedge clk); cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = ADR_STAT;
        chk("R2 no ack before edge", {7'd0, ack}, 8'h00);
        @(negedge clk);
        chk("R2 ack after one cycle", {7'd0, ack}, 8'h01);
        chk("R1 status reset", rdat, 8'h05);
        cyc = 1'b0; stb = 1'b0;
        @(negedge clk);
        chk("R2 ack single cycle", {7'd0, ack}, 8'h00);
        bus_rd(ADR_CTRL, v); chk("R1 control reset", v, 8'h00);

        // R3 readback, R6 idle level, R11 writes ignored while disabled
        bus_wr(ADR_CTRL, 8'h6D);
        bus_rd(ADR_CTRL, v); chk("R3 control readback", v, 8'h6D);
        idle(2);
        chk("R6 idle level follows polarity", {7'd0, sck}, 8'h01);
        bus_wr(ADR_DATA, 8'h55);
        bus_rd(ADR_STAT, v); chk("R11 data write ignored while disabled", v, 8'h05);

        // R6 edge timing, R4 first bit before first edge (phase 0)
        setup(8'h82);
        bus_wr(ADR_DATA, 8'h80);
        @(negedge clk);
        chk("R4 first bit before first edge", {7'd0, mosi}, 8'h01);
        t = 1;
        while (sck === 1'b0 && t < 50) begin @(negedge clk); t++; end
        chk("R6 clocks to first edge", 8'(t), 8'd5);
        t = 0;
        while (sck === 1'b1 && t < 50) begin @(negedge clk); t++; end
        chk("R6 half period", 8'(t), 8'd4);
        idle(70);
        bus_rd(ADR_STAT, v); chk("R7 status after one byte", v, 8'h81);
        bus_rd(ADR_DATA, v); chk("R5 received byte", v, resp(0));
        chk("R4 sent byte", cap_log[0], 8'h80);

        // vector table: every mode and divider
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c, tx;
            c  = VEC[i][15:8];
            tx = VEC[i][7:0];
            setup(c);
            bus_wr(ADR_DATA, tx);
            idle((16 << c[1:0]) + 4);
            bus_rd(ADR_STAT, v); chk("R7 status after byte", v, 8'h81);
            bus_rd(ADR_DATA, v); chk("R5 received byte in mode", v, resp(0));
            chk("R4 sent byte in mode", cap_log[0], tx);
            chk("R6 sck at rest", {7'd0, sck}, {7'd0, c[5]});
            chk("R6 sixteen edges", 8'(sl_bytes * 8 + sl_n), 8'd8);
        end

        // R7 queue depth, R8 collision, R9 overwrite, R4 ordering
        setup(8'h83);
        for (int i = 0; i < 5; i++) bus_wr(ADR_DATA, 8'(8'h11 * (i + 1)));
        bus_rd(ADR_STAT, v); chk("R7 transmit queue full", v, 8'h06);
        bus_wr(ADR_DATA, 8'h66);
        bus_rd(ADR_STAT, v); chk("R8 collision flagged", v, 8'h46);
        bus_wr(ADR_STAT, 8'h40);
        bus_rd(ADR_STAT, v); chk("R8 collision cleared", v, 8'h06);
        idle(5 * 130 + 20);
        bus_rd(ADR_STAT, v); chk("R9 receive queue full", v, 8'h89);
        for (int i = 1; i < 5; i++) begin
            bus_rd(ADR_DATA, v); chk("R9 oldest dropped", v, resp(i));
        end
        bus_rd(ADR_STAT, v); chk("R5 receive queue drained", v, 8'h85);
        for (int i = 0; i < 5; i++) chk("R4 byte order", cap_log[i], 8'(8'h11 * (i + 1)));
        chk("R8 dropped byte not sent", 8'(sl_bytes), 8'd5);

        // R10 interrupt after three transfers
        setup(8'hC8);
        bus_wr(ADR_DATA, 8'h01); idle(24);
        chk("R10 no int after one", {7'd0, irq_o}, 8'h00);
        bus_rd(ADR_STAT, v); chk("R10 flag clear after one", v, 8'h01);
        bus_wr(ADR_DATA, 8'h02); idle(24);
        chk("R10 no int after two", {7'd0, irq_o}, 8'h00);
        bus_wr(ADR_DATA, 8'h03); idle(24);
        chk("R10 int after three", {7'd0, irq_o}, 8'h01);
        bus_rd(ADR_STAT, v); chk("R10 flag set", v, 8'h81);
        bus_wr(ADR_STAT, 8'h80);
        chk("R10 int cleared", {7'd0, irq_o}, 8'h00);
        bus_rd(ADR_STAT, v); chk("R10 flag cleared", v, 8'h01);
        for (int i = 0; i < 3; i++) begin
            bus_rd(ADR_DATA, v); chk("R5 read order", v, resp(i));
        end
        bus_wr(ADR_CTRL, 8'h88);
        for (int i = 0; i < 3; i++) bus_wr(ADR_DATA, 8'(i + 4));
        idle(60);
        chk("R10 int masked", {7'd0, irq_o}, 8'h00);
        bus_rd(ADR_STAT, v); chk("R10 flag set again after count restart", v, 8'h81);
        bus_rd(ADR_DATA, v); chk("R5 next byte", v, resp(3));

        // R11 abort and flush
        setup(8'hA3);
        bus_wr(ADR_DATA, 8'h96);
        bus_wr(ADR_DATA, 8'h69);
        idle(40);
        model_on = 1'b0;
        bus_wr(ADR_CTRL, 8'h23);
        idle(2);
        chk("R11 sck to rest on abort", {7'd0, sck}, 8'h01);
        bus_rd(ADR_STAT, v); chk("R11 queues flushed", v, 8'h05);
        bus_wr(ADR_CTRL, 8'hA3);
        idle(300);
        bus_rd(ADR_STAT, v); chk("R11 nothing left to send", v, 8'h05);
        chk("R11 sck idle after re-enable", {7'd0, sck}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule